// File: doc/BRIEF.md
# Packed Integer to Floating-Point Vector Converter

This block takes a packed vector of integers and turns every lane into an IEEE floating-point value of the same width. Sixteen-bit integers become half-precision numbers and 32-bit integers become single-precision numbers. The source is read as two's-complement or as unsigned, as a flag selects. Rounding is fixed to round to nearest, with ties going to the even mantissa. A narrow operation converts one 64-bit bank. A wide operation converts the full 128 bits: eight half lanes or four single lanes.

All lanes work in parallel, and the packed result is registered one cycle after the input strobe. The result comes with two flags shared by all active lanes. One reports that some rounding occurred. The other reports that an unsigned 16-bit value went past the half-precision range. An operation with an unsupported size code writes nothing and raises a reject pulse instead.

Top module: `vec_int2fp_cvt`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high with a legal size code, and is low after any other edge.
- R2: Lane i takes bits [W*i +: W] of `in_vec` and writes bits [W*i +: W] of `out_vec`. `in_size`=01 selects W=16 with half-precision results (1 sign, 5 exponent, 10 mantissa bits). `in_size`=10 selects W=32 with single-precision results (1 sign, 8 exponent, 23 mantissa bits).
- R3: With `in_unsigned`=1 each lane is an unsigned integer. With `in_unsigned`=0 each lane is a two's-complement signed integer.
- R4: With `in_quad`=0 only bits [63:0] are converted and `out_vec[127:64]` is zero. The upper lanes then have no effect on either flag. With `in_quad`=1 all 128 bits are converted.
- R5: An `in_size` of 00 or 11 leaves `out_valid` low. It leaves `out_vec`, `out_inexact` and `out_overflow` unchanged, and sets `out_undef` for one cycle.
- R6: Each lane rounds to nearest. An exact tie goes to the value whose mantissa LSB is 0.
- R7: A zero input gives all-zero bits (+0.0) in both signed and unsigned modes, with no inexact contribution.
- R8: The most negative signed input converts exactly: 0x8000 gives 0xF800 and 0x80000000 gives 0xCF000000, with no inexact contribution.
- R9: An unsigned 16-bit value that rounds above 65504 (any value of 65520 or more) gives +infinity (0x7C00) and sets both `out_overflow` and `out_inexact`.
- R10: `out_inexact` is the OR of rounding loss over all active lanes of the operation.
- R11: After reset, `out_valid`, `out_undef`, `out_vec`, `out_inexact` and `out_overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| in_vec | input | 128 | Packed integer source lanes |
| in_size | input | 2 | Lane size code: 01 = 16-bit, 10 = 32-bit, others rejected |
| in_unsigned | input | 1 | 1 = unsigned source, 0 = signed source |
| in_quad | input | 1 | 1 = convert all 128 bits, 0 = low 64 bits only |
| out_valid | output | 1 | Result strobe, one cycle after the input |
| out_undef | output | 1 | Reject pulse for an unsupported size code |
| out_vec | output | 128 | Packed floating-point result |
| out_inexact | output | 1 | Some active lane was rounded |
| out_overflow | output | 1 | Some active lane overflowed to infinity |

## Verification
In a single operation, one lane can overflow to infinity while another lane rounds a tie, and the two must merge correctly into the shared flags. The bench provokes this with a directed half-precision vector that holds 65520, 65519 and tie values next to each other, and with random vectors. Each lane is compared against a reference computed with quotient and remainder arithmetic, and the flags against the OR over active lanes. A rejected size code right after a legal operation is also judged, by checking that the previous result and flags still hold.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_SINGLE = 2'b10,
    SZ_RSV_HI = 2'b11
  } size_e;

  localparam int HALF_W   = 16;
  localparam int HALF_E   = 5;
  localparam int HALF_M   = 10;
  localparam int SINGLE_W = 32;
  localparam int SINGLE_E = 8;
  localparam int SINGLE_M = 23;
endpackage

// File: rtl/cvt_rst_sync.sv
module cvt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cvt_lzc.sv
module cvt_lzc #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/cvt_lane.sv
module cvt_lane #(
  parameter int W = 16,
  parameter int E = 5,
  parameter int M = 10
) (
  input  logic [W-1:0] src,
  input  logic         uns,
  output logic [W-1:0] res,
  output logic         inexact,
  output logic         overflow
);
  localparam int CW   = $clog2(W + 1);
  localparam int LOW  = W - 1 - M;
  localparam int BIAS = (1 << (E - 1)) - 1;
  localparam int MAXE = (1 << E) - 1;

  logic          neg;
  logic [W-1:0]  mag;
  logic [W-1:0]  norm;
  logic [CW-1:0] lz;
  logic [M-1:0]  mant;
  logic          grd, rnd, stk, rnd_up;
  logic [M:0]    mant_rnd;
  logic [E:0]    exp_b;

  cvt_lzc #(.W(W)) u_lzc (
    .din (mag),
    .cnt (lz)
  );

  always_comb begin
    neg      = !uns && src[W-1];
    mag      = neg ? (~src + 1'b1) : src;
    norm     = mag << lz;
    mant     = norm[W-2 -: M];
    grd      = norm[LOW-1];
    rnd      = norm[LOW-2];
    stk      = |norm[LOW-3:0];
    rnd_up   = grd && (rnd || stk || mant[0]);
    mant_rnd = {1'b0, mant} + {{M{1'b0}}, rnd_up};
    exp_b    = (E+1)'(W - 1 + BIAS) - (E+1)'(lz) + (E+1)'(mant_rnd[M]);
    overflow = (mag != '0) && (exp_b >= (E+1)'(MAXE));
    inexact  = (mag != '0) && (grd || rnd || stk);
    if (mag == '0) begin
      res = '0;
    end else if (overflow) begin
      res = {neg, {E{1'b1}}, {M{1'b0}}};
    end else begin
      res = {neg, exp_b[E-1:0], mant_rnd[M-1:0]};
    end
  end

  always_comb begin
    if (src == '0) begin
      p_zero_pos_r7: assert (res == '0 && !inexact);
    end
    if (overflow) begin
      p_ovf_inf_r9: assert (res[W-2:0] == {{E{1'b1}}, {M{1'b0}}} && inexact && !neg);
    end
  end
endmodule

// File: rtl/vec_int2fp_cvt.sv
module vec_int2fp_cvt #(
  parameter int VEC_W  = 128,
  parameter int BANK_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_vec,
  input  logic [1:0]       in_size,
  input  logic             in_unsigned,
  input  logic             in_quad,
  output logic             out_valid,
  output logic             out_undef,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_inexact,
  output logic             out_overflow
);
  import cvt_pkg::*;

  localparam int NH      = VEC_W / HALF_W;
  localparam int NS      = VEC_W / SINGLE_W;
  localparam int NH_BANK = BANK_W / HALF_W;
  localparam int NS_BANK = BANK_W / SINGLE_W;

  logic rst_q_n;

  cvt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  logic [HALF_W-1:0]   res_h [NH];
  logic [NH-1:0]       ix_h, ov_h;
  logic [SINGLE_W-1:0] res_s [NS];
  logic [NS-1:0]       ix_s, ov_s;

  for (genvar g = 0; g < NH; g++) begin : g_half
    cvt_lane #(.W(HALF_W), .E(HALF_E), .M(HALF_M)) u_lane (
      .src      (in_vec[HALF_W*g +: HALF_W]),
      .uns      (in_unsigned),
      .res      (res_h[g]),
      .inexact  (ix_h[g]),
      .overflow (ov_h[g])
    );
  end

  for (genvar g = 0; g < NS; g++) begin : g_single
    cvt_lane #(.W(SINGLE_W), .E(SINGLE_E), .M(SINGLE_M)) u_lane (
      .src      (in_vec[SINGLE_W*g +: SINGLE_W]),
      .uns      (in_unsigned),
      .res      (res_s[g]),
      .inexact  (ix_s[g]),
      .overflow (ov_s[g])
    );
  end

  logic             legal, cen;
  logic [VEC_W-1:0] nx_vec;
  logic             nx_ix, nx_ov;

  always_comb begin
    legal  = (in_size == SZ_HALF) || (in_size == SZ_SINGLE);
    cen    = in_valid && legal;
    nx_vec = '0;
    nx_ix  = 1'b0;
    nx_ov  = 1'b0;
    if (in_size == SZ_HALF) begin
      for (int i = 0; i < NH; i++) begin
        if (i < NH_BANK || in_quad) begin
          nx_vec[HALF_W*i +: HALF_W] = res_h[i];
          nx_ix = nx_ix | ix_h[i];
          nx_ov = nx_ov | ov_h[i];
        end
      end
    end else if (in_size == SZ_SINGLE) begin
      for (int i = 0; i < NS; i++) begin
        if (i < NS_BANK || in_quad) begin
          nx_vec[SINGLE_W*i +: SINGLE_W] = res_s[i];
          nx_ix = nx_ix | ix_s[i];
          nx_ov = nx_ov | ov_s[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid    <= 1'b0;
      out_undef    <= 1'b0;
      out_vec      <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= cen;
      out_undef <= in_valid && !legal;
      if (cen) begin
        out_vec      <= nx_vec;
        out_inexact  <= nx_ix;
        out_overflow <= nx_ov;
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && legal) |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(in_valid && legal) |=> !out_valid);
  p_reject_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !legal) |=> (out_undef && !out_valid && $stable(out_vec)
                              && $stable(out_inexact) && $stable(out_overflow)));
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && legal && !in_quad) |=> (out_vec[VEC_W-1:BANK_W] == '0));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_overflow |-> out_inexact);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(out_valid && out_undef));
endmodule

// File: tb/vec_int2fp_cvt_tb_top.sv
module vec_int2fp_cvt_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_vec;
  logic [1:0]   in_size;
  logic         in_unsigned;
  logic         in_quad;
  logic         out_valid, out_undef, out_inexact, out_overflow;
  logic [127:0] out_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [127:0] last_vec = '0;
  logic         last_ix  = 1'b0;
  logic         last_ov  = 1'b0;

  always #10 clk = ~clk;

  vec_int2fp_cvt dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_vec       (in_vec),
    .in_size      (in_size),
    .in_unsigned  (in_unsigned),
    .in_quad      (in_quad),
    .out_valid    (out_valid),
    .out_undef    (out_undef),
    .out_vec      (out_vec),
    .out_inexact  (out_inexact),
    .out_overflow (out_overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // returns {overflow, inexact, 32-bit pattern}
  function automatic logic [33:0] ref_lane(input logic [31:0] x, input bit is16,
                                           input bit uns);
    int          w    = is16 ? 16 : 32;
    int          mw   = is16 ? 10 : 23;
    int          ew   = is16 ? 5 : 8;
    int          bias = is16 ? 15 : 127;
    logic [63:0] v, mag, q, rem, halfv;
    bit          neg, ix, ov;
    int          p, sh, e;
    logic [31:0] bits;
    v   = is16 ? {48'b0, x[15:0]} : {32'b0, x};
    neg = !uns && v[w-1];
    mag = neg ? ((64'd1 << w) - v) : v;
    if (mag == 0) return 34'b0;
    p = 0;
    for (int i = 0; i < 33; i++) if (mag[i]) p = i;
    sh = p - mw;
    ix = 1'b0;
    if (sh <= 0) begin
      q = mag << (-sh);
    end else begin
      q     = mag >> sh;
      rem   = mag & ((64'd1 << sh) - 1);
      halfv = 64'd1 << (sh - 1);
      ix    = (rem != 0);
      if (rem > halfv || (rem == halfv && q[0])) q = q + 1;
      if (q == (64'd1 << (mw + 1))) begin
        q = q >> 1;
        p = p + 1;
      end
    end
    e  = p + bias;
    ov = (e >= (1 << ew) - 1);
    if (ov) begin
      ix = 1'b1;
      bits = is16 ? {16'b0, neg, 5'h1f, 10'b0} : {neg, 8'hff, 23'b0};
    end else begin
      bits = is16 ? {16'b0, neg, e[4:0], q[9:0]} : {neg, e[7:0], q[22:0]};
    end
    return {ov, ix, bits};
  endfunction

  task automatic run_op(input logic [127:0] v, input logic [1:0] sz, input bit uns,
                        input bit quad, input string tag);
    logic [127:0] ev;
    bit           eix, eov, legal;
    logic [33:0]  r;
    ev    = '0;
    eix   = 1'b0;
    eov   = 1'b0;
    legal = (sz == 2'b01) || (sz == 2'b10);
    if (sz == 2'b01) begin
      for (int i = 0; i < 8; i++) begin
        if (i < 4 || quad) begin
          r = ref_lane({16'b0, v[16*i +: 16]}, 1'b1, uns);
          ev[16*i +: 16] = r[15:0];
          eix = eix | r[32];
          eov = eov | r[33];
        end
      end
    end else if (sz == 2'b10) begin
      for (int i = 0; i < 4; i++) begin
        if (i < 2 || quad) begin
          r = ref_lane(v[32*i +: 32], 1'b0, uns);
          ev[32*i +: 32] = r[31:0];
          eix = eix | r[32];
          eov = eov | r[33];
        end
      end
    end
    @(negedge clk);
    in_valid    = 1'b1;
    in_vec      = v;
    in_size     = sz;
    in_unsigned = uns;
    in_quad     = quad;
    @(negedge clk);
    in_valid = 1'b0;
    if (legal) begin
      chk(out_valid == 1'b1, "R1 valid", 128'(out_valid), 128'd1);
      chk(out_undef == 1'b0, "R5 no reject", 128'(out_undef), 128'd0);
      chk(out_vec == ev, tag, out_vec, ev);
      chk(out_inexact == eix, "R10 inexact", 128'(out_inexact), 128'(eix));
      chk(out_overflow == eov, "R9 overflow", 128'(out_overflow), 128'(eov));
      last_vec = ev;
      last_ix  = eix;
      last_ov  = eov;
    end else begin
      chk(out_valid == 1'b0, "R5 no valid", 128'(out_valid), 128'd0);
      chk(out_undef == 1'b1, "R5 reject", 128'(out_undef), 128'd1);
      chk(out_vec == last_vec, "R5 held vec", out_vec, last_vec);
      chk({out_inexact, out_overflow} == {last_ix, last_ov}, "R5 held flags",
          128'({out_inexact, out_overflow}), 128'({last_ix, last_ov}));
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk(out_valid == 1'b0 && out_undef == 1'b0, "R1 idle",
        128'({out_valid, out_undef}), 128'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    logic [1:0]   sz;
    int           k;
    void'($urandom(32'h1234_abcd));
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_vec      = '0;
    in_size     = 2'b01;
    in_unsigned = 1'b0;
    in_quad     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({out_valid, out_undef, out_inexact, out_overflow} == 4'b0 && out_vec == '0,
        "R11 reset", out_vec, 128'd0);

    run_op('0, 2'b01, 1'b0, 1'b1, "R7 zero half signed");
    run_op('0, 2'b10, 1'b1, 1'b1, "R7 zero single unsigned");
    run_op({8{16'h8000}}, 2'b01, 1'b0, 1'b1, "R8 min half");
    chk(out_vec[15:0] == 16'hF800, "R8 min half pattern", 128'(out_vec[15:0]), 128'hF800);
    run_op({4{32'h8000_0000}}, 2'b10, 1'b0, 1'b1, "R8 min single");
    chk(out_vec[31:0] == 32'hCF00_0000, "R8 min single pattern",
        128'(out_vec[31:0]), 128'hCF00_0000);
    run_op({8{16'hFFFF}}, 2'b01, 1'b1, 1'b1, "R9 max unsigned half");
    chk(out_vec[15:0] == 16'h7C00, "R9 inf pattern", 128'(out_vec[15:0]), 128'h7C00);
    run_op({16'd2051, 16'd2049, 16'd65519, 16'd65520, 16'd2051, 16'd2049,
            16'd65519, 16'd65520}, 2'b01, 1'b1, 1'b1, "R9 R6 mixed lanes");
    run_op({8{16'hFFFF}}, 2'b01, 1'b0, 1'b1, "R3 minus one half");
    chk(out_vec[15:0] == 16'hBC00, "R3 minus one pattern", 128'(out_vec[15:0]), 128'hBC00);
    run_op({32'h0100_0003, 32'h0100_0001, 32'h0100_0003, 32'h0100_0001},
           2'b10, 1'b1, 1'b1, "R6 single ties");
    run_op({{4{16'hFFFF}}, 16'd3, 16'd7, 16'd100, 16'd1}, 2'b01, 1'b1, 1'b0,
           "R4 narrow half");
    run_op({{2{32'hFFFF_FFFF}}, 32'd5, 32'd9}, 2'b10, 1'b1, 1'b0, "R4 narrow single");
    idle_chk();
    run_op({8{16'h1234}}, 2'b00, 1'b0, 1'b1, "R5 size 00");
    run_op({8{16'h1234}}, 2'b11, 1'b1, 1'b0, "R5 size 11");
    idle_chk();

    for (int n = 0; n < 300; n++) begin
      v  = {$urandom, $urandom, $urandom, $urandom};
      k  = int'($urandom % 8);
      sz = (k < 3) ? 2'b01 : (k < 6) ? 2'b10 : (k == 6) ? 2'b00 : 2'b11;
      if ($urandom % 4 == 0) v = v >> ($urandom % 100);
      run_op(v, sz, 1'($urandom), 1'($urandom), "R2 random");
      if (n % 50 == 0) idle_chk();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule